// File: doc/BRIEF.md
# Signed Fractional Multiply Unit

This block multiplies two signed fixed-point fractions and returns the product aligned for one of six result formats. A 3-bit format code selects the format. It picks whether the second operand is used as a full word, as its lower halfword or as its upper halfword. It also picks whether the result is one word or a low/high pair. A one-bit fractional-shift control doubles the product, so two fractions in Q31 or Q15 form give a correctly aligned fractional result.

Each accepted operation also produces an overflow flag and an advance-overflow flag, plus a sticky copy of each. The overflow flag reports the single case where minus one times minus one does not fit. The result is not saturated in that case; it wraps. The advance-overflow flag reports that the top two bits of the relevant result word differ. Operands are captured on a valid strobe, and results, flags and a valid strobe appear on the following clock edge.

Top module: `qmul_unit`

## Requirements
- R1: While reset is asserted and right after it, out_valid is 0 and every result and flag output is 0.
- R2: Each operation presented with in_valid high produces its results, with out_valid high, exactly one cycle later. When in_valid is low, out_valid is low on the next cycle, and results and flags keep their previous values.
- R3: Format code 0 (full by full, one word) sets res_lo to the upper word of the 64-bit signed product when frac_shift is 0. When frac_shift is 1 it sets res_lo to the product shifted right by 31, truncated to 32 bits. In both cases res_hi is 0.
- R4: Format codes 1, 3 and 5 (two-word results) return the whole 64-bit product, doubled when frac_shift is 1, with bits 31..0 on res_lo and bits 63..32 on res_hi.
- R5: Codes 2 and 3 take the second factor from src_b bits 15..0, sign-extended. Codes 4 and 5 take it from src_b bits 31..16, sign-extended. Codes 0 and 1 use all of src_b.
- R6: Codes 2 and 4 (one-word halfword formats) set res_lo to bits 47..16 of the product when frac_shift is 0, or of the doubled product when it is 1. res_hi is 0.
- R7: The overflow flag is 0 when frac_shift is 0. When frac_shift is 1 it is 1 exactly when the relevant word equals 0x80000000. The relevant word is res_hi for two-word formats and res_lo otherwise. The result is never saturated.
- R8: The advance-overflow flag equals bit 31 XOR bit 30 of the relevant word.
- R9: The sticky overflow and sticky advance-overflow flags are the OR of every overflow and advance-overflow flag since reset. They change only when an operation is accepted, and only reset clears them.
- R10: Each flag word carries its flag in bit 31; bits 30..0 are always 0.
- R11: Codes 6 and 7 behave exactly like code 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| src_a | input | 32 | First factor, signed |
| src_b | input | 32 | Second factor, or the source of its halfword |
| frac_shift | input | 1 | Double the product before alignment |
| mode | input | 3 | Format code (0..5, with 6 and 7 aliasing 0) |
| out_valid | output | 1 | Results below are from an operation |
| res_lo | output | 32 | Single-word result, or low word of a two-word result |
| res_hi | output | 32 | High word of a two-word result, else 0 |
| flag_v | output | 32 | Overflow flag in bit 31 |
| flag_sv | output | 32 | Sticky overflow flag in bit 31 |
| flag_av | output | 32 | Advance-overflow flag in bit 31 |
| flag_sav | output | 32 | Sticky advance-overflow flag in bit 31 |

## Verification
Quarter-scale positive fractions, near-full-scale values and mixed-sign values are run through every format code, with the fractional shift both on and off. This tells apart the >>32, >>31, >>16 and >>15 alignments, and shows whether the factor is taken as signed. A second operand whose lower halfword has its sign bit set and whose upper halfword is positive shows which half was picked and whether it was sign-extended. Minus one times minus one is applied in the full-word, halfword, one-word and two-word formats to show where the overflow flag fires and that the result wraps. Operations with and without advance overflow, run in sequence, show that the sticky bits hold until reset.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

    localparam int unsigned MODE_W = 3;

    // source of the second factor
    typedef enum logic [1:0] {
        SRC_FULL  = 2'd0,
        SRC_LOHALF = 2'd1,
        SRC_HIHALF = 2'd2
    } fac_src_e;

    localparam logic [MODE_W-1:0] FMT_FULL_ONE  = 3'd0;
    localparam logic [MODE_W-1:0] FMT_FULL_TWO  = 3'd1;
    localparam logic [MODE_W-1:0] FMT_LO_ONE    = 3'd2;
    localparam logic [MODE_W-1:0] FMT_LO_TWO    = 3'd3;
    localparam logic [MODE_W-1:0] FMT_HI_ONE    = 3'd4;
    localparam logic [MODE_W-1:0] FMT_HI_TWO    = 3'd5;

    // two-word result formats
    function automatic logic fmt_is_wide(input logic [MODE_W-1:0] m);
        return (m == FMT_FULL_TWO) || (m == FMT_LO_TWO) || (m == FMT_HI_TWO);
    endfunction

    // where the second factor comes from; unused codes fall back to full
    function automatic fac_src_e fmt_src(input logic [MODE_W-1:0] m);
        fac_src_e s;
        case (m)
            FMT_LO_ONE, FMT_LO_TWO: s = SRC_LOHALF;
            FMT_HI_ONE, FMT_HI_TWO: s = SRC_HIHALF;
            default:                s = SRC_FULL;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/qmul_operand_sel.sv
module qmul_operand_sel
    import qmul_pkg::*;
#(
    parameter int unsigned WORD = 32
) (
    input  logic [WORD-1:0]   src_b,
    input  logic [MODE_W-1:0] mode,
    output logic [WORD-1:0]   fac_b
);
    localparam int unsigned HALF = WORD / 2;

    fac_src_e src;

    always_comb begin
        src = fmt_src(mode);
        case (src)
            SRC_LOHALF: fac_b = {{(WORD-HALF){src_b[HALF-1]}}, src_b[HALF-1:0]};
            SRC_HIHALF: fac_b = {{(WORD-HALF){src_b[WORD-1]}}, src_b[WORD-1:HALF]};
            default:    fac_b = src_b;
        endcase
    end

endmodule

// File: rtl/qmul_align.sv
module qmul_align
    import qmul_pkg::*;
#(
    parameter int unsigned WORD = 32
) (
    input  logic [WORD-1:0]   fac_a,
    input  logic [WORD-1:0]   fac_b,
    input  logic              frac_shift,
    input  logic [MODE_W-1:0] mode,
    output logic [WORD-1:0]   word_lo,
    output logic [WORD-1:0]   word_hi,
    output logic [WORD-1:0]   rel_word
);
    localparam int unsigned HALF = WORD / 2;
    localparam int unsigned PW   = 2 * WORD;

    logic signed [PW-1:0] prod;
    logic        [PW-1:0] scaled;
    logic                 wide;
    fac_src_e             src;

    always_comb begin
        prod   = $signed(fac_a) * $signed(fac_b);
        scaled = frac_shift ? (prod << 1) : prod;
        wide   = fmt_is_wide(mode);
        src    = fmt_src(mode);
        if (wide) begin
            word_lo  = scaled[WORD-1:0];
            word_hi  = scaled[PW-1:WORD];
            rel_word = scaled[PW-1:WORD];
        end else if (src == SRC_FULL) begin
            word_lo  = scaled[PW-1:WORD];
            word_hi  = '0;
            rel_word = scaled[PW-1:WORD];
        end else begin
            word_lo  = scaled[WORD+HALF-1:HALF];
            word_hi  = '0;
            rel_word = scaled[WORD+HALF-1:HALF];
        end
    end

endmodule

// File: rtl/qmul_flags.sv
module qmul_flags #(
    parameter int unsigned WORD = 32
) (
    input  logic [WORD-1:0] rel_word,
    input  logic            frac_shift,
    output logic            ovf,
    output logic            adv
);
    localparam logic [WORD-1:0] MIN_WORD = {1'b1, {(WORD-1){1'b0}}};

    always_comb begin
        ovf = frac_shift && (rel_word == MIN_WORD);
        adv = rel_word[WORD-1] ^ rel_word[WORD-2];
    end

endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
    import qmul_pkg::*;
#(
    parameter int unsigned WORD = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD-1:0]     src_a,
    input  logic [WORD-1:0]     src_b,
    input  logic                frac_shift,
    input  logic [MODE_W-1:0]   mode,
    output logic                out_valid,
    output logic [WORD-1:0]     res_lo,
    output logic [WORD-1:0]     res_hi,
    output logic [WORD-1:0]     flag_v,
    output logic [WORD-1:0]     flag_sv,
    output logic [WORD-1:0]     flag_av,
    output logic [WORD-1:0]     flag_sav
);
    localparam int unsigned PAD = WORD - 1;

    typedef struct packed {
        logic            valid;
        logic [WORD-1:0] lo;
        logic [WORD-1:0] hi;
        logic            v;
        logic            sv;
        logic            av;
        logic            sav;
    } state_t;

    state_t st_d, st_q;

    logic [WORD-1:0] fac_b;
    logic [WORD-1:0] word_lo, word_hi, rel_word;
    logic            ovf, adv;

    qmul_operand_sel #(.WORD(WORD)) u_sel (
        .src_b (src_b),
        .mode  (mode),
        .fac_b (fac_b)
    );

    qmul_align #(.WORD(WORD)) u_align (
        .fac_a      (src_a),
        .fac_b      (fac_b),
        .frac_shift (frac_shift),
        .mode       (mode),
        .word_lo    (word_lo),
        .word_hi    (word_hi),
        .rel_word   (rel_word)
    );

    qmul_flags #(.WORD(WORD)) u_flags (
        .rel_word   (rel_word),
        .frac_shift (frac_shift),
        .ovf        (ovf),
        .adv        (adv)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.lo  = word_lo;
            st_d.hi  = word_hi;
            st_d.v   = ovf;
            st_d.av  = adv;
            st_d.sv  = st_q.sv  | ovf;
            st_d.sav = st_q.sav | adv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign res_lo    = st_q.lo;
    assign res_hi    = st_q.hi;
    assign flag_v    = {st_q.v,   {PAD{1'b0}}};
    assign flag_sv   = {st_q.sv,  {PAD{1'b0}}};
    assign flag_av   = {st_q.av,  {PAD{1'b0}}};
    assign flag_sav  = {st_q.sav, {PAD{1'b0}}};

endmodule

// File: rtl/qmul_checker.sv
module qmul_checker
    import qmul_pkg::*;
#(
    parameter int unsigned WORD = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              frac_shift,
    input logic [MODE_W-1:0] mode,
    input logic              out_valid,
    input logic [WORD-1:0]   res_lo,
    input logic [WORD-1:0]   res_hi,
    input logic [WORD-1:0]   flag_v,
    input logic [WORD-1:0]   flag_sv,
    input logic [WORD-1:0]   flag_av,
    input logic [WORD-1:0]   flag_sav
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi) && $stable(flag_sav))); // R2

    AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fmt_is_wide(mode)) |=> (res_hi == '0)); // R3

    AST_NO_SHIFT_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !frac_shift) |=> !flag_v[WORD-1]); // R7

    AST_SV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sv[WORD-1] |=> flag_sv[WORD-1]); // R9

    AST_SAV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sav[WORD-1] |=> flag_sav[WORD-1]); // R9

    AST_SV_COVERS_V: assert property (@(posedge clk) disable iff (!rst_n)
        flag_v[WORD-1] |-> flag_sv[WORD-1]); // R9

    AST_SAV_COVERS_AV: assert property (@(posedge clk) disable iff (!rst_n)
        flag_av[WORD-1] |-> flag_sav[WORD-1]); // R9

    AST_FLAG_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v[WORD-2:0] == '0) && (flag_sv[WORD-2:0] == '0) &&
        (flag_av[WORD-2:0] == '0) && (flag_sav[WORD-2:0] == '0)); // R10

endmodule

bind qmul_unit qmul_checker #(.WORD(WORD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .frac_shift (frac_shift),
    .mode       (mode),
    .out_valid  (out_valid),
    .res_lo     (res_lo),
    .res_hi     (res_hi),
    .flag_v     (flag_v),
    .flag_sv    (flag_sv),
    .flag_av    (flag_av),
    .flag_sav   (flag_sav)
);

// File: tb/tb_qmul_unit.sv
module tb_qmul_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        frac_shift = 1'b0;
    logic [2:0]  mode = '0;
    logic        out_valid;
    logic [31:0] res_lo, res_hi, flag_v, flag_sv, flag_av, flag_sav;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit exp_sv = 1'b0;
    bit exp_sav = 1'b0;

    always #10 clk = ~clk;

    qmul_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .frac_shift(frac_shift), .mode(mode), .out_valid(out_valid),
        .res_lo(res_lo), .res_hi(res_hi), .flag_v(flag_v), .flag_sv(flag_sv),
        .flag_av(flag_av), .flag_sav(flag_sav)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // expected values straight from the requirement text
    task automatic model(input logic [31:0] a, input logic [31:0] b, input bit n, input logic [2:0] m,
                         output logic [31:0] lo, output logic [31:0] hi, output bit v, output bit av);
        logic signed [31:0] fb;
        logic signed [63:0] pr;
        logic [31:0] rel;
        case (m)
            3'd2, 3'd3: fb = {{16{b[15]}}, b[15:0]};            // R5
            3'd4, 3'd5: fb = {{16{b[31]}}, b[31:16]};           // R5
            default:    fb = b;
        endcase
        pr = 64'($signed(a)) * 64'(fb);
        if (n) pr = pr << 1;
        case (m)
            3'd1, 3'd3, 3'd5: begin lo = pr[31:0];  hi = pr[63:32]; rel = hi; end // R4
            3'd2, 3'd4:       begin lo = pr[47:16]; hi = '0;        rel = lo; end // R6
            default:          begin lo = pr[63:32]; hi = '0;        rel = lo; end // R3 R11
        endcase
        v  = n && (rel == 32'h8000_0000);   // R7
        av = rel[31] ^ rel[30];             // R8
    endtask

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input bit n,
                          input logic [2:0] m, input string tag);
        logic [31:0] elo, ehi;
        bit ev, eav;
        model(a, b, n, m, elo, ehi, ev, eav);
        exp_sv  = exp_sv | ev;
        exp_sav = exp_sav | eav;
        @(negedge clk);
        src_a = a; src_b = b; frac_shift = n; mode = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R2 out_valid", 64'(out_valid), 64'd1);
        chk(res_lo == elo, {tag, " res_lo"}, 64'(res_lo), 64'(elo));
        chk(res_hi == ehi, {tag, " res_hi"}, 64'(res_hi), 64'(ehi));
        chk(flag_v == {ev, 31'd0}, "R7 flag_v", 64'(flag_v), 64'({ev, 31'd0}));
        chk(flag_av == {eav, 31'd0}, "R8 flag_av", 64'(flag_av), 64'({eav, 31'd0}));
        chk(flag_sv == {exp_sv, 31'd0}, "R9 flag_sv", 64'(flag_sv), 64'({exp_sv, 31'd0}));
        chk(flag_sav == {exp_sav, 31'd0}, "R9 R10 flag_sav", 64'(flag_sav), 64'({exp_sav, 31'd0}));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        exp_sv = 1'b0;
        exp_sav = 1'b0;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
        chk((res_lo | res_hi | flag_v | flag_sv | flag_av | flag_sav) == '0, "R1 outputs in reset",
            64'(res_lo | res_hi | flag_v | flag_sv | flag_av | flag_sav), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && flag_sav == '0 && flag_sv == '0, "R1 after release",
            64'(flag_sav | flag_sv), 64'd0);
    endtask

    task automatic t_full_one();
        run_op(32'h4000_0000, 32'h4000_0000, 1'b0, 3'd0, "R3 half*half");
        run_op(32'h4000_0000, 32'h4000_0000, 1'b1, 3'd0, "R3 half*half shifted");
        run_op(32'h7FFF_FFFF, 32'hC000_0000, 1'b1, 3'd0, "R3 mixed sign");
        run_op(32'h1234_5678, 32'h7654_3210, 1'b0, 3'd0, "R3 generic");
    endtask

    task automatic t_wide();
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 3'd1, "R4 full two-word");
        run_op(32'h8765_4321, 32'h0ABC_DEF1, 1'b1, 3'd1, "R4 full two-word shifted");
        run_op(32'h4000_0001, 32'h1234_8000, 1'b1, 3'd3, "R4 R5 low half two-word");
        run_op(32'hC000_0003, 32'h8001_0000, 1'b0, 3'd5, "R4 R5 high half two-word");
    endtask

    task automatic t_half_one();
        run_op(32'h4000_0000, 32'h1234_8000, 1'b0, 3'd2, "R5 R6 low half");
        run_op(32'h4000_0000, 32'h1234_8000, 1'b1, 3'd2, "R5 R6 low half shifted");
        run_op(32'h4000_0000, 32'h1234_8000, 1'b0, 3'd4, "R5 R6 high half");
        run_op(32'hF000_0001, 32'h9ABC_4321, 1'b1, 3'd4, "R5 R6 high half shifted");
    endtask

    task automatic t_minus_one_squared();
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 3'd0, "R7 wrap full one-word");
        chk(res_lo == 32'h8000_0000 && flag_v[31], "R7 no saturation", 64'(res_lo), 64'h8000_0000);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 3'd1, "R7 wrap full two-word");
        run_op(32'h8000_0000, 32'h0000_8000, 1'b1, 3'd2, "R7 wrap low half");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 3'd5, "R7 high half two-word");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 3'd0, "R7 unshifted");
    endtask

    task automatic t_sticky();
        t_reset();
        run_op(32'h1000_0000, 32'h1000_0000, 1'b0, 3'd0, "R9 quiet");
        run_op(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 3'd0, "R9 advance");
        run_op(32'h1000_0000, 32'h1000_0000, 1'b0, 3'd0, "R9 quiet again");
        chk(flag_sav[31] == 1'b1 && flag_av[31] == 1'b0, "R9 sav held", 64'(flag_sav), 64'h8000_0000);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 3'd0, "R9 overflow");
        run_op(32'h0100_0000, 32'h0100_0000, 1'b1, 3'd1, "R9 after overflow");
        chk(flag_sv[31] == 1'b1 && flag_v[31] == 1'b0, "R9 sv held", 64'(flag_sv), 64'h8000_0000);
    endtask

    task automatic t_hold();
        logic [31:0] lo0, hi0, sv0, sav0;
        run_op(32'h7FFF_0000, 32'h8000_1234, 1'b1, 3'd1, "R2 before idle");
        lo0 = res_lo; hi0 = res_hi; sv0 = flag_sv; sav0 = flag_sav;
        src_a = 32'h8000_0000; src_b = 32'h8000_0000; frac_shift = 1'b1; mode = 3'd0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2 idle out_valid", 64'(out_valid), 64'd0);
        chk(res_lo == lo0 && res_hi == hi0, "R2 idle results held", {res_hi, res_lo}, {hi0, lo0});
        chk(flag_sv == sv0 && flag_sav == sav0, "R2 R9 idle flags held", {flag_sv, flag_sav}, {sv0, sav0});
    endtask

    task automatic t_alias();
        run_op(32'h2345_6789, 32'h9876_5432, 1'b0, 3'd6, "R11 code 6");
        run_op(32'h8000_0000, 32'h8000_0000, 1'b1, 3'd7, "R11 code 7");
        run_op(32'h7000_0000, 32'h0000_7FFF, 1'b1, 3'd7, "R11 code 7 full word");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_full_one();
        t_wide();
        t_half_one();
        t_minus_one_squared();
        t_hold();
        t_alias();
        t_sticky();
        t_reset();
        finish_run();
    end

endmodule